// File: doc/BRIEF.md
# Dual-Arm Retract Start-Up Sequencer

This block brings two actuator arms into a safe, retracted position before a production phase is allowed to start. A single-cycle start pulse makes it issue a retract command to both arms at once. From then on each arm is followed by its own branch. Each branch watches a 12-bit position reading. When the reading falls to or below a retract limit, the branch issues a stop command to that arm and finishes.

The two branches never wait for each other. Either arm may arrive first, or both may arrive in the same cycle. A join combines them and raises a one-cycle done pulse in the same cycle that the later branch finishes. After done, the sequencer is idle. It ignores position changes until a new start pulse arrives or reset is applied.

All command outputs are combinational from the current inputs and a small amount of branch state. A controller therefore sees its commands in the same cycle as the event that causes them.

Top module: `dual_arm_retract_seq`

## Requirements
- R1: While idle, a high `start_i` makes `retract_a_o` and `retract_b_o` both high in that same cycle, for exactly that one cycle.
- R2: An arm counts as arrived when its position input is less than or equal to parameter `RETRACT_LIMIT` (default 100). A position of 101 does not count as arrived; a position of exactly 100 does.
- R3: After the start cycle, the first cycle in which an arm has arrived makes that arm's stop output (`stop_a_o` or `stop_b_o`) high for that one cycle. The stop output stays low afterwards for the rest of the sequence, even if the position leaves and returns.
- R4: An arrived position during the start cycle itself is ignored: no stop output in the start cycle. A position that is still arrived in the next cycle gives the stop in that next cycle.
- R5: The two arms are handled independently. Arm A may stop before arm B, arm B before arm A, or both in the same cycle.
- R6: `done_o` is high for one cycle, in the cycle of the later of the two stop pulses. When both arms stop in the same cycle, that is the cycle of both stop pulses. `done_o` is never high in any other cycle.
- R7: After done, every output stays low whatever the position inputs do, until the next start.
- R8: A start pulse during a running sequence produces no retract command and does not change when the stops or done occur.
- R9: While reset is asserted and right after it is released, every output is low. A new start after done runs a complete new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request pulse |
| pos_a_i | input | 12 | Arm A position reading |
| pos_b_i | input | 12 | Arm B position reading |
| retract_a_o | output | 1 | Retract command pulse, arm A |
| retract_b_o | output | 1 | Retract command pulse, arm B |
| stop_a_o | output | 1 | Stop command pulse, arm A |
| stop_b_o | output | 1 | Stop command pulse, arm B |
| done_o | output | 1 | Both arms stopped pulse |

## Verification
Two pairs of events can fall in the same cycle. The first pair is an arm's stop and the join's done. The second pair is the two arms' stops, which may coincide with each other and with done.

The bench provokes the coincidence in two ways. It lowers both positions at the same negative edge, and it holds both positions low across the start cycle so that both waits end in the first cycle they are allowed to.

It judges the result by sampling within the cycle. It expects both stops and done together, with done absent in the start cycle and in every other cycle. In the staggered cases done must appear only alongside the later stop.

// File: rtl/retract_seq_pkg.sv
package retract_seq_pkg;
  localparam int unsigned ARM_COUNT = 2;
  localparam int unsigned ARM_A = 0;
  localparam int unsigned ARM_B = 1;
endpackage

// File: rtl/retract_arm_branch.sv
module retract_arm_branch #(
  parameter int unsigned POS_W = 12,
  parameter logic [POS_W-1:0] LIMIT = POS_W'(100)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch_i,
  input  logic             clear_i,
  input  logic [POS_W-1:0] pos_i,
  output logic             retract_o,
  output logic             stop_o,
  output logic             finished_o,
  output logic             active_o
);
  logic wait_q, wait_d;
  logic cmpl_q, cmpl_d;
  logic arrived;
  logic wait_en, cmpl_en;

  assign arrived   = (pos_i <= LIMIT);
  assign retract_o = launch_i;
  assign stop_o    = wait_q & arrived;
  assign finished_o = cmpl_q | stop_o;
  assign active_o  = wait_q | cmpl_q;

  always_comb begin
    wait_en = launch_i | stop_o;
    wait_d  = launch_i;
    cmpl_en = stop_o | clear_i;
    cmpl_d  = ~clear_i & (cmpl_q | stop_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= 1'b0;
    end else if (wait_en) begin
      wait_q <= wait_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmpl_q <= 1'b0;
    end else if (cmpl_en) begin
      cmpl_q <= cmpl_d;
    end
  end
endmodule

// File: rtl/retract_join.sv
module retract_join #(
  parameter int unsigned N = 2
) (
  input  logic [N-1:0] finished_i,
  input  logic [N-1:0] active_i,
  input  logic         start_i,
  output logic         done_o,
  output logic         launch_o
);
  assign done_o   = &finished_i;
  assign launch_o = start_i & ~(|active_i);
endmodule

// File: rtl/dual_arm_retract_seq.sv
module dual_arm_retract_seq #(
  parameter int unsigned POS_W = 12,
  parameter logic [POS_W-1:0] RETRACT_LIMIT = POS_W'(100)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [POS_W-1:0] pos_a_i,
  input  logic [POS_W-1:0] pos_b_i,
  output logic             retract_a_o,
  output logic             retract_b_o,
  output logic             stop_a_o,
  output logic             stop_b_o,
  output logic             done_o
);
  import retract_seq_pkg::*;

  logic [POS_W-1:0]     pos_v [ARM_COUNT];
  logic [ARM_COUNT-1:0] retract_v, stop_v, fin_v, act_v;
  logic                 launch, done;

  assign pos_v[ARM_A] = pos_a_i;
  assign pos_v[ARM_B] = pos_b_i;

  retract_join #(.N(ARM_COUNT)) u_join (
    .finished_i(fin_v),
    .active_i  (act_v),
    .start_i   (start_i),
    .done_o    (done),
    .launch_o  (launch)
  );

  for (genvar g = 0; g < ARM_COUNT; g++) begin : g_arm
    retract_arm_branch #(.POS_W(POS_W), .LIMIT(RETRACT_LIMIT)) u_branch (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch_i  (launch),
      .clear_i   (done),
      .pos_i     (pos_v[g]),
      .retract_o (retract_v[g]),
      .stop_o    (stop_v[g]),
      .finished_o(fin_v[g]),
      .active_o  (act_v[g])
    );
  end

  assign retract_a_o = retract_v[ARM_A];
  assign retract_b_o = retract_v[ARM_B];
  assign stop_a_o    = stop_v[ARM_A];
  assign stop_b_o    = stop_v[ARM_B];
  assign done_o      = done;
endmodule

// File: rtl/dual_arm_retract_chk.sv
module dual_arm_retract_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic retract_a_o,
  input logic retract_b_o,
  input logic stop_a_o,
  input logic stop_b_o,
  input logic done_o
);
  // R1
  pair_retract_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retract_a_o == retract_b_o);
  // R1
  retract_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retract_a_o |-> start_i);
  // R4
  no_stop_at_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retract_a_o |-> (!stop_a_o && !stop_b_o));
  // R3
  stop_a_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_a_o |=> !stop_a_o);
  // R3
  stop_b_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_b_o |=> !stop_b_o);
  // R6
  done_with_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (stop_a_o || stop_b_o));
  // R7
  done_then_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !stop_a_o && !stop_b_o));
endmodule

bind dual_arm_retract_seq dual_arm_retract_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .retract_a_o(retract_a_o),
  .retract_b_o(retract_b_o),
  .stop_a_o   (stop_a_o),
  .stop_b_o   (stop_b_o),
  .done_o     (done_o)
);

// File: tb/sim_dual_arm_retract_seq.sv
`timescale 1ns/1ps
module sim_dual_arm_retract_seq;
  logic clk, rst_n, start_i;
  logic [11:0] pos_a_i, pos_b_i;
  logic retract_a_o, retract_b_o, stop_a_o, stop_b_o, done_o;
  int checks, errors;

  localparam logic [11:0] FAR = 12'd4000;

  dual_arm_retract_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .pos_a_i(pos_a_i), .pos_b_i(pos_b_i),
    .retract_a_o(retract_a_o), .retract_b_o(retract_b_o),
    .stop_a_o(stop_a_o), .stop_b_o(stop_b_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // expected vector order: retract_a retract_b stop_a stop_b done
  task automatic expect_out(input logic [4:0] exp, input string req);
    logic [4:0] act;
    act = {retract_a_o, retract_b_o, stop_a_o, stop_b_o, done_o};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // advance to next negedge, apply inputs, let comb settle
  task automatic cyc(input logic st, input logic [11:0] pa, input logic [11:0] pb);
    @(negedge clk);
    start_i = st; pos_a_i = pa; pos_b_i = pb;
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start_i = 1'b0; pos_a_i = 12'd0; pos_b_i = 12'd0;
    #1 expect_out(5'b00000, "R9 during reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(1'b0, 12'd0, 12'd0);
    expect_out(5'b00000, "R9 after reset");
  endtask

  task automatic t_a_first();
    cyc(1'b1, FAR, FAR);   expect_out(5'b11000, "R1 start");
    cyc(1'b0, FAR, FAR);   expect_out(5'b00000, "R3 waiting");
    cyc(1'b0, 12'd101, FAR); expect_out(5'b00000, "R2 101 not arrived");
    cyc(1'b0, 12'd50, FAR);  expect_out(5'b00100, "R5 arm A first");
    cyc(1'b0, 12'd50, FAR);  expect_out(5'b00000, "R3 stop once");
    cyc(1'b0, FAR, FAR);     expect_out(5'b00000, "R3 no restop");
    cyc(1'b0, 12'd10, 12'd100); expect_out(5'b00011, "R2 R6 limit equal, done");
    cyc(1'b0, 12'd0, 12'd0); expect_out(5'b00000, "R7 inert");
    cyc(1'b0, FAR, 12'd0);   expect_out(5'b00000, "R7 inert");
  endtask

  task automatic t_b_first_restart_ignored();
    cyc(1'b1, FAR, FAR);     expect_out(5'b11000, "R9 rerun start");
    cyc(1'b1, FAR, FAR);     expect_out(5'b00000, "R8 start while busy");
    cyc(1'b0, FAR, 12'd3);   expect_out(5'b00010, "R5 arm B first");
    cyc(1'b1, FAR, FAR);     expect_out(5'b00000, "R8 start while half done");
    cyc(1'b0, 12'd99, FAR);  expect_out(5'b00101, "R6 done on later stop A");
    cyc(1'b0, FAR, FAR);     expect_out(5'b00000, "R7 no second done");
  endtask

  task automatic t_both_at_launch();
    cyc(1'b1, 12'd0, 12'd0); expect_out(5'b11000, "R4 arrival at start ignored");
    cyc(1'b0, 12'd0, 12'd0); expect_out(5'b00111, "R4 R6 both stop and done");
    cyc(1'b0, 12'd0, 12'd0); expect_out(5'b00000, "R7 inert after joint done");
  endtask

  task automatic t_both_same_later();
    cyc(1'b1, FAR, FAR);     expect_out(5'b11000, "R1 start again");
    cyc(1'b0, FAR, FAR);     expect_out(5'b00000, "R3 waiting");
    cyc(1'b0, 12'd7, 12'd8); expect_out(5'b00111, "R5 R6 simultaneous");
    cyc(1'b0, FAR, FAR);     expect_out(5'b00000, "R6 single done");
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    t_reset();
    t_a_first();
    t_b_first_restart_ignored();
    t_both_at_launch();
    t_both_same_later();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule